// File: doc/BRIEF.md
# Integral-Image Corner Set Rebuilder

This block sits on the return path of an integral-image fetch engine that leaves out addresses it already read in the previous round. Each round of a box-filter evaluation needs a full set of 32 corner values. For a filter size of 9, the memory front end sends all 32 values in the first round of a row, 30 in the second round and 20 in every later round. This block accepts that shortened word stream. It places each word in the slot it belongs to and fills the omitted slots from per-lane copy FIFOs. Those FIFOs captured the matching values of the previous round. The complete 32-entry set is then presented together with a one-cycle valid pulse.

Words arrive with a valid strobe. The first word of each image row also carries a row-start flag. That flag puts the block back into the first-round pattern and discards any half-built round and any stored copy data. Slots are numbered 1 to 32. Slot k occupies bits [(k-1)*W +: W] of the output set.

Top module: `iimg_set_rebuild`

## Requirements
- R1: While reset is high, and on the first cycle after it, `set_valid` is 0 and `set_data` is all zeros.
- R2: In the first round of a row, 32 words are accepted and written in arrival order into slots 1 to 32.
- R3: In the second round, 30 words are accepted into every slot except 6 and 8. Slot 6 receives the first round's slot 2 and slot 8 receives the first round's slot 4.
- R4: From the third round on, 20 words are accepted into slots 2, 4, 5, 7, 9–20 and 29–32. The other slots take values from the previous round: slot 1 from slot 5, slot 3 from slot 7, slot 6 from slot 2, slot 8 from slot 4, slots 21–24 from slots 29–32 and slots 25–28 from slots 17–20.
- R5: A disabled slot consumes no input word. The next accepted word goes to the next enabled slot in ascending order.
- R6: `set_valid` is high for exactly one cycle. That cycle follows the clock edge that accepted the last enabled word of the round. `set_data` keeps its value until the next pulse.
- R7: Cycles with `in_valid` low change neither the slot position nor any stored value.
- R8: A word with `in_valid` and `in_row_start` both high discards any partial round and all copy data. That word becomes slot 1 of a new first round.
- R9: No copy FIFO is pushed while full unless it is also popped in that cycle, and none is popped while empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An integral-image word is present |
| in_row_start | input | 1 | The present word is the first of an image row |
| in_data | input | W | Integral-image word |
| set_valid | output | 1 | One-cycle pulse: `set_data` holds a complete round |
| set_data | output | 32*W | Rebuilt corner set, slot k at bits [(k-1)*W +: W] |

## Verification
The only latency in the block is the output register. The complete set and its valid pulse appear one clock after the edge that accepts the last enabled word of a round. A row-start word acts at the same edge that accepts it. A behavioural model in the bench rebuilds the expected set from lists of enabled slots and source slots. The model advances at the same rising edge as the design, and its results are compared with the outputs at every falling edge, so each result is checked in the exact cycle it is due. The stimulus covers long rounds, rounds with random idle gaps, back-to-back rounds and a restart in the middle of a row.

// File: rtl/rebuild_pkg.sv
package rebuild_pkg;
  localparam int NSLOT  = 32;
  localparam int NLANE  = 12;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef enum logic [1:0] {RND_FIRST, RND_SECOND, RND_STEADY} rnd_e;

  // slot indices are 0-based here
  function automatic logic slot_on(rnd_e r, int s);
    case (r)
      RND_FIRST:  return 1'b1;
      RND_SECOND: return !(s == 5 || s == 7);
      default:    return !(s == 0 || s == 2 || s == 5 || s == 7 ||
                           (s >= 20 && s <= 27));
    endcase
  endfunction

  function automatic int lane_src(int k);
    case (k)
      0: return 1;
      1: return 3;
      2: return 4;
      3: return 6;
      default: return (k < 8) ? 12 + k : 20 + k;
    endcase
  endfunction

  function automatic int lane_dst(int k);
    case (k)
      0: return 5;
      1: return 7;
      2: return 0;
      3: return 2;
      default: return (k < 8) ? 20 + k : 12 + k;
    endcase
  endfunction

  function automatic logic lane_push_on(rnd_e r, int k);
    return (r != RND_FIRST) || (k < 2);
  endfunction

  function automatic logic lane_pop_on(rnd_e r, int k);
    return (r == RND_STEADY) || (r == RND_SECOND && k < 2);
  endfunction

  function automatic rnd_e rnd_next(rnd_e r);
    return (r == RND_FIRST) ? RND_SECOND : RND_STEADY;
  endfunction

  function automatic logic [SLOT_W-1:0] first_on(rnd_e r);
    logic [SLOT_W-1:0] f;
    f = '0;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (slot_on(r, s)) f = SLOT_W'(s);
    return f;
  endfunction
endpackage

// File: rtl/rebuild_seq.sv
module rebuild_seq
  import rebuild_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_row_start,
  output logic [SLOT_W-1:0] slot_idx,
  output rnd_e              rnd,
  output logic              round_done,
  output logic              restart
);
  logic [SLOT_W-1:0] ptr_q, nxt_ptr;
  rnd_e              rnd_q;
  logic              found;

  assign restart  = in_valid && in_row_start;
  assign slot_idx = restart ? '0 : ptr_q;
  assign rnd      = restart ? RND_FIRST : rnd_q;

  always_comb begin
    nxt_ptr = slot_idx;
    found   = 1'b0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (s > int'(slot_idx) && slot_on(rnd, s)) begin
        nxt_ptr = SLOT_W'(s);
        found   = 1'b1;
      end
    end
  end

  assign round_done = in_valid && !found;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      rnd_q <= RND_FIRST;
    end else if (round_done) begin
      rnd_q <= rnd_next(rnd);
      ptr_q <= first_on(rnd_next(rnd));
    end else if (in_valid) begin
      rnd_q <= rnd;
      ptr_q <= nxt_ptr;
    end
  end
endmodule

// File: rtl/rebuild_fifo.sv
module rebuild_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign head  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/rebuild_assemble.sv
module rebuild_assemble
  import rebuild_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [W-1:0]                wr_data,
  input  logic                        done,
  input  rnd_e                        rnd,
  input  logic [NLANE-1:0][W-1:0]     copy_head,
  output logic                        set_valid,
  output logic [NSLOT*W-1:0]          set_data
);
  logic [W-1:0]                slot_q [NSLOT];
  logic [NSLOT-1:0][W-1:0]     nxt_set, set_q;
  logic                        valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_slot] <= wr_data;
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      nxt_set[s] = slot_q[s];
      if (int'(wr_slot) == s) begin
        nxt_set[s] = wr_data;
      end else if (!slot_on(rnd, s)) begin
        for (int k = 0; k < NLANE; k++)
          if (lane_dst(k) == s) nxt_set[s] = copy_head[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      set_q   <= '0;
    end else begin
      valid_q <= done;
      if (done) set_q <= nxt_set;
    end
  end

  assign set_valid = valid_q;
  assign set_data  = set_q;
endmodule

// File: rtl/iimg_set_rebuild.sv
module iimg_set_rebuild
  import rebuild_pkg::*;
#(
  parameter int W          = 16,
  parameter int COPY_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_row_start,
  input  logic [W-1:0]         in_data,
  output logic                 set_valid,
  output logic [NSLOT*W-1:0]   set_data
);
  logic [SLOT_W-1:0]       slot_idx;
  rnd_e                    rnd;
  logic                    round_done, restart;
  logic [NLANE-1:0]        lane_push, lane_pop, lane_full, lane_empty;
  logic [NLANE-1:0][W-1:0] lane_head;

  rebuild_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_row_start (in_row_start),
    .slot_idx     (slot_idx),
    .rnd          (rnd),
    .round_done   (round_done),
    .restart      (restart)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int SRC = lane_src(k);
    assign lane_push[k] = in_valid && (int'(slot_idx) == SRC) && lane_push_on(rnd, k);
    assign lane_pop[k]  = round_done && lane_pop_on(rnd, k);

    rebuild_fifo #(.W(W), .DEPTH(COPY_DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .flush (restart),
      .push  (lane_push[k]),
      .pop   (lane_pop[k]),
      .wdata (in_data),
      .head  (lane_head[k]),
      .full  (lane_full[k]),
      .empty (lane_empty[k])
    );
  end

  rebuild_assemble #(.W(W)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (in_valid),
    .wr_slot   (slot_idx),
    .wr_data   (in_data),
    .done      (round_done),
    .rnd       (rnd),
    .copy_head (lane_head),
    .set_valid (set_valid),
    .set_data  (set_data)
  );
endmodule

// File: rtl/rebuild_chk.sv
module rebuild_chk
  import rebuild_pkg::*;
#(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_row_start,
  input logic               set_valid,
  input logic [NSLOT*W-1:0] set_data,
  input logic [NLANE-1:0]   lane_push,
  input logic [NLANE-1:0]   lane_pop,
  input logic [NLANE-1:0]   lane_full,
  input logic [NLANE-1:0]   lane_empty
);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (lane_push & lane_full & ~lane_pop) == '0);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (lane_pop & lane_empty) == '0);

  assert_pulse_after_word_R6: assert property (@(posedge clk) disable iff (rst)
    set_valid |-> $past(in_valid));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    set_valid |=> !set_valid);

  assert_set_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !set_valid |-> $stable(set_data));

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_row_start) |=> (&lane_empty && !set_valid));
endmodule

bind iimg_set_rebuild rebuild_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_row_start (in_row_start),
  .set_valid    (set_valid),
  .set_data     (set_data),
  .lane_push    (lane_push),
  .lane_pop     (lane_pop),
  .lane_full    (lane_full),
  .lane_empty   (lane_empty)
);

// File: tb/iimg_set_rebuild_tb.sv
module iimg_set_rebuild_tb;
  localparam int W  = 16;
  localparam int NS = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_row_start = 1'b0;
  logic [W-1:0]    in_data = '0;
  logic            set_valid;
  logic [NS*W-1:0] set_data;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    finished = 0;
  string tag = "R1";
  logic [W-1:0] dgen = 16'h1234;
  logic [7:0]   lfsr = 8'hA5;

  always #2 clk = ~clk;

  iimg_set_rebuild #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_row_start(in_row_start),
    .in_data(in_data), .set_valid(set_valid), .set_data(set_data)
  );

  // ---------------- behavioural reference model ----------------
  int              m_rnd, m_cnt;
  logic [W-1:0]    m_cur  [1:NS];
  logic [W-1:0]    m_prev [1:NS];
  logic            exp_valid;
  logic [NS*W-1:0] exp_set;

  function automatic bit m_on(int r, int s);
    if (r == 0) return 1;
    if (r == 1) return !(s == 6 || s == 8);
    return !(s == 1 || s == 3 || s == 6 || s == 8 || (s >= 21 && s <= 28));
  endfunction

  function automatic int m_src(int s);
    if (s == 1) return 5;
    if (s == 3) return 7;
    if (s == 6) return 2;
    if (s == 8) return 4;
    if (s >= 21 && s <= 24) return s + 8;
    return s - 8;
  endfunction

  function automatic int m_count(int r);
    int n = 0;
    for (int s = 1; s <= NS; s++) if (m_on(r, s)) n++;
    return n;
  endfunction

  function automatic int m_nth(int r, int n);
    int c = 0;
    for (int s = 1; s <= NS; s++) begin
      if (m_on(r, s)) begin
        if (c == n) return s;
        c++;
      end
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rnd = 0; m_cnt = 0; exp_valid = 0; exp_set = '0;
    end else begin
      exp_valid = 0;
      if (in_valid) begin
        if (in_row_start) begin m_rnd = 0; m_cnt = 0; end
        m_cur[m_nth(m_rnd, m_cnt)] = in_data;
        m_cnt++;
        if (m_cnt == m_count(m_rnd)) begin
          for (int s = 1; s <= NS; s++)
            if (!m_on(m_rnd, s)) m_cur[s] = m_prev[m_src(s)];
          for (int s = 1; s <= NS; s++) begin
            exp_set[(s-1)*W +: W] = m_cur[s];
            m_prev[s] = m_cur[s];
          end
          exp_valid = 1;
          m_rnd = (m_rnd < 2) ? m_rnd + 1 : 2;
          m_cnt = 0;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (set_valid !== exp_valid || set_data !== exp_set) begin
        failures++;
        $display("FAIL %s: valid=%0b set=%h expected valid=%0b set=%h",
                 tag, set_valid, set_data, exp_valid, exp_set);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic word(bit first);
    @(negedge clk);
    dgen = dgen * 16'h9E37 + 16'h0101;
    in_valid = 1'b1; in_row_start = first; in_data = dgen;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_row_start = 1'b0;
    end
  endtask

  task automatic round(bit first, int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (lfsr[0]) idle(1 + int'(lfsr[2:1]));
      end
      word(first && i == 0);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (set_valid !== 1'b0 || set_data !== '0) begin
      failures++;
      $display("FAIL R1: valid=%0b set=%h expected valid=0 set=0", set_valid, set_data);
    end
    rst = 1'b0;
    idle(2);
    tag = "R2"; round(1, 32, 0); idle(2);
    tag = "R3"; round(0, 30, 0); idle(2);
    tag = "R4"; round(0, 20, 0); idle(1);
    tag = "R5"; round(0, 20, 0);
    tag = "R6"; idle(6);
    // R9: back-to-back rounds keep the copy FIFOs busy every cycle
    tag = "R9"; round(0, 20, 0); round(0, 20, 0); round(0, 20, 0); idle(2);
    tag = "R7"; round(1, 32, 1); round(0, 30, 1); round(0, 20, 1); round(0, 20, 1);
    idle(3);
    tag = "R8"; round(1, 32, 0); round(0, 11, 0);
    round(1, 32, 0); round(0, 30, 0); round(0, 20, 0); round(0, 7, 0);
    round(1, 32, 0); round(0, 30, 0); round(0, 20, 0);
    idle(4);
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end
endmodule